// File: doc/BRIEF.md
# Wakeup Interrupt Trigger Normalizer

This is a single-pin conditioning channel. It sits between a raw interrupt line and a downstream interrupt controller that accepts only two kinds of input: active-high levels and rising edges. A 3-bit trigger code in the channel's configuration word selects one of several behaviours:

- inversion of active-low and falling-edge sources;
- detection of single edges;
- detection of both edges.

Whatever the source polarity, the controller therefore sees an active-high level or a one-cycle high pulse.

A mode input chooses between two ways of presenting the result. In pass-through operation the conditioned signal goes straight to the output. In latched operation every qualifying event sets a sticky status bit, and the output is held high for as long as that bit stays set. Software removes a latched event by rewriting the configuration word with the status bit at zero. Edge sources are normally cleared when the interrupt is acknowledged, and level sources when its handling ends.

An enable bit and a mask bit gate both the output and the capture of events. The raw input passes through a two-stage synchronizer before any detection takes place.

Top module: `wtn_top`

## Requirements
- R1: After reset, rd_data reads 0 and irq_out is low. This means trigger code 000, enable 0, mask 0 and status 0.
- R2: The configuration word has the following layout, and bits [31:6] always read as zero:
  - bits [2:0]: trigger code
  - bit 3: enable
  - bit 4: mask
  - bit 5: status

  A write with wr_en high stores bits [5:0] of wr_data, and the stored value is readable on rd_data from the next cycle.
- R3: With trigger code 100 (level active-high) in pass-through operation, irq_out follows irq_in after two clock edges.
- R4: With trigger code 000 (level active-low) in pass-through operation, irq_out is the inverse of irq_in after two clock edges.
- R5: With trigger code 110 (rising edge), a 0-to-1 input transition gives irq_out a pulse exactly one cycle wide, starting two edges after the change. A 1-to-0 transition gives no pulse.
- R6: With trigger code 010 (falling edge), a 1-to-0 transition gives a one-cycle high pulse. A 0-to-1 transition gives no pulse.
- R7: With trigger code 111 (both edges), every input transition gives a one-cycle high pulse.
- R8: While the enable bit is 0, irq_out is low and the status bit is not set by input events.
- R9: While the mask bit is 1, irq_out is low and the status bit is not set by input events, in both operating modes.
- R10: In latched operation a qualifying event sets the status bit one edge after the event becomes visible. The status bit then stays set until it is written to 0, and irq_out equals the status bit. In pass-through operation no event sets the status bit.
- R11: A write with bit 5 at 0 clears the status bit at that edge. The write takes priority over an event in the same cycle.
- R12: A change of latch_mode takes effect at the next clock edge. Until that edge, irq_out keeps the behaviour of the previous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| latch_mode | input | 1 | 0 = pass-through, 1 = latched operation |
| irq_in | input | 1 | Raw asynchronous interrupt line |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | REG_W | Configuration write data |
| rd_data | output | REG_W | Configuration word readback |
| irq_out | output | 1 | Normalized interrupt to the controller |

## Verification
The bench measures pulse width and latency for each trigger code. This exposes two faults: a detector that compares against the wrong sample gives two-cycle pulses, and one that skips a synchronizer stage fires an edge early. Falling and active-low codes are checked for the polarity of the output, and rising and falling codes are each driven with the opposite transition, so that a detector answering both edges is reported.

The status bit is cleared while a level source is still active. This shows whether a write wins over a same-cycle event, and also that the event re-latches on the following edge. Masked and disabled channels are watched in latched operation, where a wrong gate shows up as a status bit that sets silently. The mode input is changed with a latched event pending, to confirm the switch waits for the next clock edge.

// File: rtl/wtn_pkg.sv
// Shared types for the trigger normalizer channel.
// Assumes the configuration word occupies the low bits of the register.
package wtn_pkg;

    // Trigger codes; bit 2 = active-high polarity, bit 1 = edge, bits 1&0 = both edges
    typedef enum logic [2:0] {
        TRG_LVL_LOW   = 3'b000,
        TRG_EDGE_FALL = 3'b010,
        TRG_LVL_HIGH  = 3'b100,
        TRG_EDGE_RISE = 3'b110,
        TRG_EDGE_BOTH = 3'b111
    } trig_e;

    // Packed in register bit order: status[5], mask[4], enable[3], trigger[2:0]
    typedef struct packed {
        logic       status;
        logic       mask;
        logic       en;
        logic [2:0] trig;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

endpackage

// File: rtl/wtn_sync.sv
// Multi-stage synchronizer for the raw interrupt line.
// Assumes STAGES >= 2; output lags the input by STAGES edges.
module wtn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wtn_detect.sv
// Trigger detector: normalizes polarity and finds edges per the trigger code.
// Assumes smp is already synchronized; hit is a level (level codes) or a
// one-cycle pulse (edge codes).
module wtn_detect
    import wtn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp,
    input  logic [2:0] trig,
    output logic       hit
);
    logic prev;
    logic invert, is_edge, is_dual;
    logic cur_n, prv_n;

    // Hold the previous synchronized sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= smp;
    end

    // Decode the trigger code and form the normalized event
    always_comb begin
        invert  = ~trig[2];
        is_edge = trig[1];
        is_dual = trig[1] & trig[0];
        cur_n   = smp ^ invert;
        prv_n   = prev ^ invert;
        if (is_dual)      hit = smp ^ prev;
        else if (is_edge) hit = cur_n & ~prv_n;
        else              hit = cur_n;
    end
endmodule

// File: rtl/wtn_cfg.sv
// Configuration register with a sticky status bit.
// Assumes a software write takes priority over a same-cycle status set.
module wtn_cfg
    import wtn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  cfg_t wr_cfg,
    input  logic set_status,
    output cfg_t cfg
);
    // Store writes, otherwise latch events into the status bit
    always_ff @(posedge clk) begin
        if (!rst_n)          cfg <= '0;
        else if (wr_en)      cfg <= wr_cfg;
        else if (set_status) cfg.status <= 1'b1;
    end
endmodule

// File: rtl/wtn_top.sv
// Wakeup interrupt trigger normalizer, one pin.
// Converts any trigger kind to active-high level or rising pulse, with an
// optional sticky latched mode. Assumes irq_in is asynchronous to clk.
module wtn_top
    import wtn_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_mode,
    input  logic             irq_in,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_out
);
    localparam int PAD_W = REG_W - CFG_W;

    logic smp, hit, mode_q, gate, set_status;
    cfg_t cfg;
    logic unused_hi;

    assign unused_hi = ^wr_data[REG_W-1:CFG_W];

    wtn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(smp)
    );

    wtn_detect u_det (
        .clk(clk), .rst_n(rst_n), .smp(smp), .trig(cfg.trig), .hit(hit)
    );

    wtn_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_cfg(cfg_t'(wr_data[CFG_W-1:0])),
        .set_status(set_status), .cfg(cfg)
    );

    // Register the operating mode so it switches on the next edge
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= latch_mode;
    end

    // Gate events, capture in latched mode, select the output source
    always_comb begin
        gate       = cfg.en & ~cfg.mask;
        set_status = mode_q & gate & hit;
        irq_out    = gate & (mode_q ? cfg.status : hit);
        rd_data    = {{PAD_W{1'b0}}, cfg};
    end
endmodule

// File: rtl/wtn_chk.sv
// Property checker for wtn_top, attached by bind below.
// Assumes the low six readback bits are the configuration word.
module wtn_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [5:0] wr_data,
    input logic [5:0] rd_data,
    input logic       irq_out,
    input logic       mode_q
);
    a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[4:0] == $past(wr_data[4:0]));

    a_r8_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[3] |-> !irq_out);

    a_r9_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> !irq_out);

    a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] && !wr_en |=> rd_data[5]);

    a_r10_no_set_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q && !rd_data[5] && !wr_en |=> !rd_data[5]);

    a_r11_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data[5] |=> !rd_data[5]);
endmodule

bind wtn_top wtn_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data[5:0]),
    .rd_data(rd_data[5:0]), .irq_out(irq_out), .mode_q(mode_q)
);

// File: tb/sim_wtn_top.sv
`timescale 1ns/1ps
module sim_wtn_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        latch_mode = 1'b0;
    logic        irq_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_out;
    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    wtn_top u0 (
        .clk(clk), .rst_n(rst_n), .latch_mode(latch_mode), .irq_in(irq_in),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_regmap;
        wr(32'hFFFF_FFEC);
        chk("R2 upper zero / readback", rd_data, 32'h2C);
        wr(32'h0);
        chk("R2 clear readback", rd_data, 32'h0);
    endtask

    task automatic t_level_high;
        wr(32'h0C);
        irq_in = 1'b1; tick(1);
        chk("R3 not yet through sync", {31'b0, irq_out}, 32'h0);
        tick(1);
        chk("R3 high after two edges", {31'b0, irq_out}, 32'h1);
        irq_in = 1'b0; tick(2);
        chk("R3 low follows", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_level_low;
        wr(32'h08);
        chk("R4 low input gives high", {31'b0, irq_out}, 32'h1);
        irq_in = 1'b1; tick(2);
        chk("R4 high input gives low", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_rise;
        wr(32'h0E);
        irq_in = 1'b0; tick(3);
        chk("R5 idle", {31'b0, irq_out}, 32'h0);
        irq_in = 1'b1; tick(2);
        chk("R5 pulse on rise", {31'b0, irq_out}, 32'h1);
        tick(1);
        chk("R5 pulse one cycle", {31'b0, irq_out}, 32'h0);
        irq_in = 1'b0; tick(2);
        chk("R5 no pulse on fall", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_fall;
        wr(32'h0A);
        irq_in = 1'b1; tick(2);
        chk("R6 no pulse on rise", {31'b0, irq_out}, 32'h0);
        tick(1);
        irq_in = 1'b0; tick(2);
        chk("R6 pulse on fall", {31'b0, irq_out}, 32'h1);
        tick(1);
        chk("R6 pulse one cycle", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_dual;
        wr(32'h0F);
        irq_in = 1'b1; tick(2);
        chk("R7 pulse on rise", {31'b0, irq_out}, 32'h1);
        tick(1);
        chk("R7 pulse one cycle", {31'b0, irq_out}, 32'h0);
        irq_in = 1'b0; tick(2);
        chk("R7 pulse on fall", {31'b0, irq_out}, 32'h1);
        tick(1);
    endtask

    task automatic t_disable;
        wr(32'h04);
        irq_in = 1'b1; tick(3);
        chk("R8 disabled output low", {31'b0, irq_out}, 32'h0);
        latch_mode = 1'b1; tick(3);
        chk("R8 disabled no latch", rd_data, 32'h04);
        latch_mode = 1'b0; irq_in = 1'b0; tick(3);
    endtask

    task automatic t_mask;
        wr(32'h1C);
        irq_in = 1'b1; tick(3);
        chk("R9 masked output low", {31'b0, irq_out}, 32'h0);
        latch_mode = 1'b1; tick(3);
        chk("R9 masked no latch", rd_data, 32'h1C);
        chk("R9 masked latched out low", {31'b0, irq_out}, 32'h0);
        irq_in = 1'b0; tick(3);
    endtask

    task automatic t_latch;
        latch_mode = 1'b1;
        wr(32'h0E);
        tick(3);
        chk("R10 idle status", rd_data, 32'h0E);
        irq_in = 1'b1; tick(2);
        chk("R10 not yet latched", {31'b0, irq_out}, 32'h0);
        tick(1);
        chk("R10 status set", rd_data, 32'h2E);
        chk("R10 output high", {31'b0, irq_out}, 32'h1);
        irq_in = 1'b0; tick(5);
        chk("R10 output held", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_clear;
        wr(32'h0E);
        chk("R11 write clears status", rd_data, 32'h0E);
        chk("R11 output drops", {31'b0, irq_out}, 32'h0);
        wr(32'h0C);
        irq_in = 1'b1; tick(3);
        chk("R10 level latched", rd_data, 32'h2C);
        wr(32'h0C);
        chk("R11 write wins over event", rd_data, 32'h0C);
        tick(1);
        chk("R10 level relatches", rd_data, 32'h2C);
        irq_in = 1'b0; tick(2);
        wr(32'h0C);
        tick(2);
        chk("R11 stays clear", rd_data, 32'h0C);
    endtask

    task automatic t_mode;
        wr(32'h2E);
        chk("R12 latched out", {31'b0, irq_out}, 32'h1);
        latch_mode = 1'b0; #1;
        chk("R12 old mode until edge", {31'b0, irq_out}, 32'h1);
        tick(1);
        chk("R12 pass-through after edge", {31'b0, irq_out}, 32'h0);
        latch_mode = 1'b1; tick(1);
        chk("R12 latched again", {31'b0, irq_out}, 32'h1);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        tick(1);
        t_reset;
        t_regmap;
        t_level_high;
        t_level_low;
        t_rise;
        t_fall;
        t_dual;
        t_disable;
        t_mask;
        t_latch;
        t_clear;
        t_mode;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule